// File: doc/BRIEF.md
# DDR Two-Beat Data Serializer and Strobe Unit

This block sits between a memory core that moves one double-width word per core clock and an external data bus half that width that moves two beats per core clock. It is modelled on a single fast clock running at twice the core rate, so each external beat lasts one fast cycle and each internal word spans two fast cycles. On the read side a burst request starts a sequence with four parts. First the strobe is driven low as a preamble. Then each captured word is split into two beats, with the strobe toggling on the same edges as the data. Then the strobe is held low for a short postamble. Finally both output enables are released.

On the write side the unit samples the incoming strobe and data every fast cycle. The external controller places each strobe transition one fast cycle after the matching data change, which models the centre-aligned write timing. A rising strobe transition latches the lower half of a word and a falling transition latches the upper half. The rebuilt word is then presented together with a one-cycle valid pulse. Strobe activity is ignored while the unit is driving the strobe for a read.

Top module: `ddr_prefetch_io`

## Requirements
- R1: While reset is asserted, and after it is released with no burst requested, `dqs_oe`, `dq_oe`, `dqs_out` and `wr_valid` are 0 and `dq_out` is all zeros.
- R2: The burst length is taken from `rd_bl` on the start edge. Code 0 gives 2 beats, code 1 gives 4 beats, and codes 2 and 3 give 8 beats. Later changes of `rd_bl` do not affect a running burst.
- R3: A burst starts on a clock edge where the unit is idle and `rd_valid` is 1. For the two fast cycles after that edge, `dqs_oe` is 1 while `dqs_out` and `dq_oe` are 0 (preamble).
- R4: Word j of a burst is sampled from `rd_word` on the (2j)-th edge after the start edge, where the start edge counts as edge 0. Its bits [DQ_W-1:0] appear on `dq_out` for beat 2j and its upper bits for beat 2j+1. Beats occupy fast cycles 2 to BL+1 after the start edge, with `dq_oe` set to 1 throughout.
- R5: While beats are driven, `dqs_out` is 1 on even beats and 0 on odd beats, so every strobe change coincides with a data change.
- R6: In the fast cycle after the last beat, `dqs_oe` stays 1 while `dqs_out` and `dq_oe` are 0 (postamble). One cycle later both enables are 0. `dq_out` is all zeros whenever `dq_oe` is 0.
- R7: `rd_valid` is ignored while a burst runs. A new request is accepted on the first edge after the release.
- R8: The unit compares `dqs_in` at each edge with the level it sampled on the previous edge. A 0-to-1 change latches, as the lower half, the `dq_in` value sampled one edge earlier. A later 1-to-0 change takes that earlier-sampled value as the upper half. The cycle after the falling change, `wr_valid` is 1 for exactly one cycle and `wr_word` is {upper, lower}.
- R9: Strobe changes seen on an edge where `dqs_oe` is 1 are ignored. A falling change with no accepted rising change before it produces no word.
- R10: `dq_oe` is never 1 while `dqs_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the core rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read burst request, sampled while idle |
| rd_bl | input | 2 | Burst length code |
| rd_word | input | 2*DQ_W | Internal read word |
| dq_out | output | DQ_W | Outgoing data beat |
| dq_oe | output | 1 | Data bus drive enable |
| dqs_out | output | 1 | Outgoing strobe level |
| dqs_oe | output | 1 | Strobe drive enable |
| dq_in | input | DQ_W | Incoming write data beat |
| dqs_in | input | 1 | Incoming write strobe level |
| wr_word | output | 2*DQ_W | Reassembled write word |
| wr_valid | output | 1 | One-cycle pulse marking a new `wr_word` |

## Verification
The properties assume that the write strobe stays low outside write pairs. They also assume that each rising strobe change is followed by a falling one before the next rising change, so valid pulses are always separated by at least one idle cycle. The bench meets these assumptions by generating every write pair with a strictly alternating strobe that starts and ends low. During reads it toggles the strobe input freely, because the unit must ignore the line while it drives it. Read stimulus presents new words only on the even edges where the unit samples them and puts junk on the odd edges, so a misplaced sample shows up as wrong data.

// File: rtl/ddr_pfx_pkg.sv
package ddr_pfx_pkg;

  localparam int unsigned MAX_BEATS = 8;
  localparam int unsigned PRE_CYC   = 2;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PRE,
    PH_BEAT,
    PH_POST
  } rd_phase_e;

  // burst length code -> number of external beats
  function automatic int unsigned beats_of(input logic [1:0] code);
    case (code)
      2'd0:    return 2;
      2'd1:    return 4;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/ddr_pfx_rd.sv
module ddr_pfx_rd
  import ddr_pfx_pkg::*;
#(
  parameter int unsigned DQ_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [1:0]        rd_bl,
  input  logic [2*DQ_W-1:0] rd_word,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              dqs_out,
  output logic              dqs_oe,
  output logic              rd_start
);

  localparam int unsigned WORD_W = 2 * DQ_W;
  localparam int unsigned CW     = $clog2(MAX_BEATS + PRE_CYC + 2);

  function automatic logic [DQ_W-1:0] half_of(input logic [WORD_W-1:0] w,
                                              input logic upper);
    return upper ? w[WORD_W-1:DQ_W] : w[DQ_W-1:0];
  endfunction

  logic              act;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     beats;
  logic [WORD_W-1:0] stage_q;
  logic [WORD_W-1:0] hold_q;

  logic [CW-1:0] cnt_nx;
  logic [CW-1:0] last_cnt;
  logic [CW-1:0] bidx;
  logic          take;
  logic          load;
  logic          done;
  rd_phase_e     phase;

  assign rd_start = !act && rd_valid;
  assign cnt_nx   = cnt + CW'(1);
  assign last_cnt = beats + CW'(PRE_CYC);
  assign done     = act && (cnt == last_cnt);
  assign take     = rd_start || (act && !cnt_nx[0] && (cnt_nx < beats));
  assign load     = act && !cnt_nx[0];
  assign bidx     = cnt - CW'(PRE_CYC);

  always_comb begin
    if (!act)                    phase = PH_IDLE;
    else if (cnt < CW'(PRE_CYC)) phase = PH_PRE;
    else if (cnt < last_cnt)     phase = PH_BEAT;
    else                         phase = PH_POST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= 1'b0;
      cnt   <= '0;
      beats <= '0;
    end else if (rd_start) begin
      act   <= 1'b1;
      cnt   <= '0;
      beats <= CW'(beats_of(rd_bl));
    end else if (done) begin
      act   <= 1'b0;
    end else if (act) begin
      cnt   <= cnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      hold_q  <= '0;
    end else begin
      if (take) stage_q <= rd_word;
      if (load) hold_q  <= stage_q;
    end
  end

  assign dqs_oe  = (phase != PH_IDLE);
  assign dq_oe   = (phase == PH_BEAT);
  assign dqs_out = dq_oe && !bidx[0];
  assign dq_out  = dq_oe ? half_of(hold_q, bidx[0]) : '0;

endmodule

// File: rtl/ddr_pfx_wr.sv
module ddr_pfx_wr #(
  parameter int unsigned DQ_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DQ_W-1:0]   dq_in,
  input  logic              dqs_in,
  input  logic              busy,
  output logic [2*DQ_W-1:0] wr_word,
  output logic              wr_valid
);

  logic [DQ_W-1:0] dq_d;
  logic [DQ_W-1:0] lo_q;
  logic            dqs_q;
  logic            have_lo;
  logic            rise;
  logic            fall;

  assign rise = !busy && dqs_in && !dqs_q;
  assign fall = !busy && !dqs_in && dqs_q && have_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_d     <= '0;
      dqs_q    <= 1'b0;
      lo_q     <= '0;
      have_lo  <= 1'b0;
      wr_word  <= '0;
      wr_valid <= 1'b0;
    end else begin
      dq_d     <= dq_in;
      dqs_q    <= dqs_in;
      wr_valid <= fall;
      if (rise) begin
        lo_q    <= dq_d;
        have_lo <= 1'b1;
      end
      if (fall) begin
        wr_word <= {dq_d, lo_q};
        have_lo <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ddr_prefetch_io.sv
module ddr_prefetch_io #(
  parameter int unsigned DQ_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [1:0]        rd_bl,
  input  logic [2*DQ_W-1:0] rd_word,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              dqs_out,
  output logic              dqs_oe,
  input  logic [DQ_W-1:0]   dq_in,
  input  logic              dqs_in,
  output logic [2*DQ_W-1:0] wr_word,
  output logic              wr_valid
);

  logic rd_start;

  ddr_pfx_rd #(.DQ_W(DQ_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .rd_bl    (rd_bl),
    .rd_word  (rd_word),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .dqs_out  (dqs_out),
    .dqs_oe   (dqs_oe),
    .rd_start (rd_start)
  );

  ddr_pfx_wr #(.DQ_W(DQ_W)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .dq_in    (dq_in),
    .dqs_in   (dqs_in),
    .busy     (dqs_oe),
    .wr_word  (wr_word),
    .wr_valid (wr_valid)
  );

endmodule

// File: rtl/ddr_pfx_chk.sv
module ddr_pfx_chk #(
  parameter int unsigned DQ_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_start,
  input logic [DQ_W-1:0] dq_out,
  input logic            dq_oe,
  input logic            dqs_out,
  input logic            dqs_oe,
  input logic            wr_valid
);

  // R10
  oe_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> dqs_oe);

  // R3
  preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> (dqs_oe && !dqs_out && !dq_oe));

  // R3
  rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dqs_oe) |-> (!dqs_out && !dq_oe));

  // R5
  first_beat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> dqs_out);

  // R5
  strobe_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> (dqs_out != $past(dqs_out)));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dqs_oe |-> (!dq_oe && !dqs_out && dq_out == '0));

  // R6
  postamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> (dqs_oe && !dqs_out));

  // R8
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dqs_oe) |-> !wr_valid);

endmodule

bind ddr_prefetch_io ddr_pfx_chk #(.DQ_W(DQ_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_start (rd_start),
  .dq_out   (dq_out),
  .dq_oe    (dq_oe),
  .dqs_out  (dqs_out),
  .dqs_oe   (dqs_oe),
  .wr_valid (wr_valid)
);

// File: tb/ddr_prefetch_io_bench.sv
`timescale 1ns/1ps
module ddr_prefetch_io_bench;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_valid = 1'b0;
  logic [1:0]    rd_bl = 2'd0;
  logic [2*DW-1:0] rd_word = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  logic          dqs_out;
  logic          dqs_oe;
  logic [DW-1:0] dq_in = '0;
  logic          dqs_in = 1'b0;
  logic [2*DW-1:0] wr_word;
  logic          wr_valid;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ddr_prefetch_io #(.DQ_W(DW)) u_ddr_prefetch_io (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_bl(rd_bl),
    .rd_word(rd_word), .dq_out(dq_out), .dq_oe(dq_oe), .dqs_out(dqs_out),
    .dqs_oe(dqs_oe), .dq_in(dq_in), .dqs_in(dqs_in), .wr_word(wr_word),
    .wr_valid(wr_valid)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %h exp %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [2*DW-1:0] wgen(input int s, input int j);
    int v;
    v = (s * 40503 + j * 2654435 + 12345) ^ (j << 9) ^ (s << 3);
    return v[2*DW-1:0];
  endfunction

  function automatic logic [DW-1:0] bgen(input int s, input int k);
    int v;
    v = s * 29 + k * 13 + 7 + (k << 5);
    return v[DW-1:0];
  endfunction

  function automatic int blen(input logic [1:0] code);
    return (code == 2'd0) ? 2 : (code == 2'd1) ? 4 : 8;
  endfunction

  task automatic check_idle(input string req);
    chk(req, {29'd0, dqs_oe, dq_oe, dqs_out}, 32'd0);
    chk(req, {24'd0, dq_out}, 32'd0);
  endtask

  task automatic run_read(input logic [1:0] code, input int seed, input bit keep_hi);
    int bl;
    bl = blen(code);
    rd_valid = 1'b1;
    rd_bl    = code;
    rd_word  = wgen(seed, 0);
    dqs_in   = 1'b0;
    @(posedge clk);
    for (int n = 0; n <= bl + 3; n++) begin
      @(negedge clk);
      if (n <= bl + 2) begin
        bit beat;
        int b;
        logic [2*DW-1:0] w;
        logic [DW-1:0] e_dq;
        string tag;
        beat = (n >= 2) && (n < bl + 2);
        b    = n - 2;
        w    = wgen(seed, (b < 0) ? 0 : b / 2);
        e_dq = beat ? ((b % 2 == 1) ? w[2*DW-1:DW] : w[DW-1:0]) : '0;
        tag  = (n < 2) ? "R3" : (beat ? "R2" : "R6");
        chk(tag, {30'd0, dqs_oe, dq_oe}, {30'd0, 1'b1, beat});
        chk("R5", {31'd0, dqs_out}, {31'd0, beat && (b % 2 == 0)});
        chk(keep_hi ? "R7" : "R4", {24'd0, dq_out}, {24'd0, e_dq});
      end else begin
        check_idle("R6");
      end
      chk("R9", {31'd0, wr_valid}, 32'd0);
      if (n < bl + 3) begin
        rd_valid = keep_hi;
        rd_bl    = ~code;
        if (((n + 1) % 2 == 0) && ((n + 1) / 2 < bl / 2))
          rd_word = wgen(seed, (n + 1) / 2);
        else
          rd_word = wgen(seed + 777, n);
        dqs_in = (n >= bl) ? 1'b1 : n[0];
      end else begin
        rd_valid = 1'b0;
        dqs_in   = 1'b0;
      end
    end
    // falling strobe with no accepted rising change yields no word
    @(negedge clk);
    chk("R9", {31'd0, wr_valid}, 32'd0);
    check_idle("R7");
  endtask

  task automatic run_write(input int pairs, input int seed);
    for (int k = 0; k <= 2 * pairs + 2; k++) begin
      if (k >= 1) begin
        int kk;
        bit ev;
        kk = k - 1;
        ev = (kk >= 2) && (kk % 2 == 0) && (kk <= 2 * pairs);
        chk("R8", {31'd0, wr_valid}, {31'd0, ev});
        if (ev)
          chk("R8", {16'd0, wr_word}, {16'd0, bgen(seed, kk - 1), bgen(seed, kk - 2)});
        chk("R10", {31'd0, dq_oe}, 32'd0);
      end
      dq_in  = (k < 2 * pairs) ? bgen(seed, k) : '0;
      dqs_in = (k < 2 * pairs) ? k[0] : 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    chk("R1", {31'd0, wr_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");
    chk("R1", {31'd0, wr_valid}, 32'd0);

    for (int code = 0; code < 4; code++)
      for (int s = 0; s < 6; s++)
        run_read(code[1:0], s * 7 + code, s[0]);

    for (int p = 1; p <= 4; p++)
      for (int s = 0; s < 5; s++)
        run_write(p, s * 11 + p);

    run_read(2'd1, 99, 1'b0);
    run_write(3, 5);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule